// File: doc/BRIEF.md
# Revertive Input Clock Selector

This block decides which of two reference inputs, called A and B, feeds a downstream phase-locked loop, or whether that loop should hold its last frequency (holdover) because no input can be trusted. It runs on a system clock. For each input it receives two alarm flags that are computed elsewhere: loss of signal and frequency offset. A qualifier for each input turns these flags into a single "usable" flag. That flag only rises after the input has been alarm-free for a programmable validation window.

A two-bit mode field sets how the choice is made:
- In manual mode a two-bit select field alone names the input.
- In automatic mode a priority rule chooses among the usable inputs. A is preferred, then B, then holdover, unless the priority-swap bit reverses A and B.
- Automatic mode is either revertive or non-revertive. Revertive mode returns to the preferred input once it is usable again. Non-revertive mode keeps the current input for as long as it remains usable.

The block reports the current choice, a holdover flag and a status code that shows the choice only in automatic mode. It also gives a one-cycle pulse on every change of choice, so that downstream phase logic can re-lock.

Top module: `refsel`

## Requirements
- R1: While reset is low and in the cycle after it is released, active = 2'b00 (holdover), holdover = 1, sel_changed = 0, sel_report = 2'b00, and neither input is usable.
- R2: An input becomes usable only after L = VAL_UNIT * 4^val_time consecutive clock edges at which both of its alarm flags are low. A single edge with an alarm restarts the count. In automatic mode the choice can move to a newly usable input at the edge after it becomes usable, which is L+1 edges after its good run starts.
- R3: An edge that samples an alarm on an input removes its usable flag at once. If that input was chosen in automatic mode, the choice moves to the other usable input, or to holdover, on the following edge.
- R4: With mode = 2'b00 (manual), man_sel = 2'b01 selects A (active = 2'b01), 2'b10 selects B (active = 2'b10), and 2'b00 or 2'b11 selects holdover. This takes effect at the next edge and does not depend on any alarm.
- R5: In automatic mode with prio_swap = 0 the order is A, then B, then holdover.
- R6: With prio_swap = 1 the order is B, then A, then holdover.
- R7: With mode[1] = 1 (revertive), the choice returns to the preferred input at the edge after that input becomes usable again.
- R8: With mode = 2'b01 (non-revertive), a chosen input that stays usable is kept even when the preferred input becomes usable.
- R9: In automatic mode the choice is holdover (holdover = 1) whenever neither input is usable. It leaves holdover only once an input has completed its validation window.
- R10: sel_report equals active in automatic mode and is 2'b00 in manual mode.
- R11: sel_changed is high for exactly those cycles in which active differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_los | input | 2 | Loss-of-signal alarm per input (bit 0 = A, bit 1 = B) |
| ref_fos | input | 2 | Frequency-offset alarm per input (bit 0 = A, bit 1 = B) |
| mode | input | 2 | 00 manual, 01 automatic non-revertive, 1x automatic revertive |
| man_sel | input | 2 | Manual choice: 01 A, 10 B, 00/11 holdover |
| prio_swap | input | 1 | 1 makes B preferred over A |
| val_time | input | 2 | Validation window exponent: L = VAL_UNIT * 4^val_time |
| active | output | 2 | Current choice: 01 A, 10 B, 00 holdover |
| holdover | output | 1 | High while active is holdover |
| sel_report | output | 2 | Current choice in automatic mode, 00 in manual mode |
| sel_changed | output | 1 | One-cycle pulse when the choice changes |

## Verification
The bench builds the block with VAL_UNIT = 2, so the four validation windows are 2, 8, 32 and 128 cycles. With windows that short, every window setting can be swept under both priority orders, and the off-by-one edge of each window can be checked directly. All sixteen alarm patterns are swept under every manual code. A long pseudo-random phase, in which alarms, modes and the priority bit change, is compared cycle by cycle against a model built from the requirements. That phase reaches revertive and non-revertive returns, runs in and out of holdover, and validation restarts many times.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    PICK_HOLD = 2'b00,
    PICK_A    = 2'b01,
    PICK_B    = 2'b10
  } pick_t;

  localparam logic [1:0] MODE_MANUAL = 2'b00;
  localparam logic [1:0] MODE_STICKY = 2'b01;

  // Validation window length in clock edges
  function automatic int unsigned qual_len(input int unsigned unit, input logic [1:0] vt);
    return unit << (2 * vt);
  endfunction

  function automatic pick_t manual_pick(input logic [1:0] code);
    case (code)
      2'b01:   return PICK_A;
      2'b10:   return PICK_B;
      default: return PICK_HOLD;
    endcase
  endfunction

  // Priority choice among usable inputs; sticky keeps a still-usable current input
  function automatic pick_t auto_pick(input logic [1:0] ok, input logic swap,
                                      input pick_t cur, input logic sticky);
    pick_t pref;
    pick_t alt;
    logic  ok_pref;
    logic  ok_alt;
    pref    = swap ? PICK_B : PICK_A;
    alt     = swap ? PICK_A : PICK_B;
    ok_pref = swap ? ok[1] : ok[0];
    ok_alt  = swap ? ok[0] : ok[1];
    if (sticky && cur == PICK_A && ok[0]) return PICK_A;
    if (sticky && cur == PICK_B && ok[1]) return PICK_B;
    if (ok_pref) return pref;
    if (ok_alt)  return alt;
    return PICK_HOLD;
  endfunction

endpackage

// File: rtl/refsel_qual.sv
module refsel_qual #(
  parameter int unsigned VAL_UNIT = 256,
  parameter int unsigned CNT_W    = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bad,
  input  logic [1:0] vt,
  output logic       ok
);
  import refsel_pkg::*;

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = CNT_W'(qual_len(VAL_UNIT, vt) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      ok      <= 1'b0;
    end else if (bad) begin
      run_cnt <= '0;
      ok      <= 1'b0;
    end else if (!ok) begin
      if (run_cnt >= last_idx) ok <= 1'b1;
      else                     run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/refsel_arb.sv
module refsel_arb (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ok,
  input  logic [1:0]           mode,
  input  logic [1:0]           man_sel,
  input  logic                 prio_swap,
  output refsel_pkg::pick_t    pick,
  output logic                 chg
);
  import refsel_pkg::*;

  pick_t nxt;

  always_comb begin
    if (mode == MODE_MANUAL) nxt = manual_pick(man_sel);
    else                     nxt = auto_pick(ok, prio_swap, pick, mode == MODE_STICKY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pick <= PICK_HOLD;
      chg  <= 1'b0;
    end else begin
      pick <= nxt;
      chg  <= (nxt != pick);
    end
  end
endmodule

// File: rtl/refsel.sv
module refsel #(
  parameter int unsigned VAL_UNIT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_los,
  input  logic [1:0] ref_fos,
  input  logic [1:0] mode,
  input  logic [1:0] man_sel,
  input  logic       prio_swap,
  input  logic [1:0] val_time,
  output logic [1:0] active,
  output logic       holdover,
  output logic [1:0] sel_report,
  output logic       sel_changed
);
  import refsel_pkg::*;

  localparam int unsigned NUM_REF = 2;
  localparam int unsigned MAX_LEN = VAL_UNIT * 64;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [NUM_REF-1:0] ref_bad;
  logic [NUM_REF-1:0] ref_ok;
  pick_t              pick;

  for (genvar i = 0; i < NUM_REF; i++) begin : g_qual
    assign ref_bad[i] = ref_los[i] | ref_fos[i];
    refsel_qual #(.VAL_UNIT(VAL_UNIT), .CNT_W(CNT_W)) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .bad  (ref_bad[i]),
      .vt   (val_time),
      .ok   (ref_ok[i])
    );
  end

  refsel_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ok       (ref_ok),
    .mode     (mode),
    .man_sel  (man_sel),
    .prio_swap(prio_swap),
    .pick     (pick),
    .chg      (sel_changed)
  );

  assign active     = pick;
  assign holdover   = (pick == PICK_HOLD);
  assign sel_report = (mode == MODE_MANUAL) ? 2'b00 : pick;
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ref_los,
  input logic [1:0] ref_fos,
  input logic [1:0] mode,
  input logic [1:0] man_sel,
  input logic       prio_swap,
  input logic [1:0] ref_ok,
  input logic [1:0] active,
  input logic       sel_changed
);
  // R3
  alarm_drops_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_los[0] | ref_fos[0]) |=> !ref_ok[0]);

  // R4
  manual_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && man_sel == 2'b01) |=> active == 2'b01);

  // R5
  prio_a_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !prio_swap && ref_ok[0]) |=> active == 2'b01);

  // R6
  prio_b_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && prio_swap && ref_ok[1]) |=> active == 2'b10);

  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && active == 2'b10 && ref_ok[1]) |=> active == 2'b10);

  // R9
  hold_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00 && ref_ok == 2'b00) |=> active == 2'b00);

  // R11
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_changed == (active != $past(active)));
endmodule

bind refsel refsel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_los    (ref_los),
  .ref_fos    (ref_fos),
  .mode       (mode),
  .man_sel    (man_sel),
  .prio_swap  (prio_swap),
  .ref_ok     (ref_ok),
  .active     (active),
  .sel_changed(sel_changed)
);

// File: tb/sim_refsel.sv
module sim_refsel;
  localparam int unsigned UNIT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_los = 2'b00;
  logic [1:0] ref_fos = 2'b00;
  logic [1:0] mode = 2'b10;
  logic [1:0] man_sel = 2'b00;
  logic       prio_swap = 1'b0;
  logic [1:0] val_time = 2'b00;
  logic [1:0] active;
  logic       holdover;
  logic [1:0] sel_report;
  logic       sel_changed;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_run [2];
  bit m_q [2];
  int m_pick = 0;
  bit m_chg = 0;

  always #2 clk = ~clk;

  refsel #(.VAL_UNIT(UNIT)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_los(ref_los), .ref_fos(ref_fos),
    .mode(mode), .man_sel(man_sel), .prio_swap(prio_swap), .val_time(val_time),
    .active(active), .holdover(holdover), .sel_report(sel_report),
    .sel_changed(sel_changed)
  );

  function automatic int win(input logic [1:0] vt);
    int w = UNIT;
    for (int k = 0; k < vt; k++) w = w * 4;
    return w;
  endfunction

  // expected next choice: 0 hold, 1 A, 2 B
  function automatic int want(input logic [1:0] md, input logic [1:0] ms,
                              input bit sw, input bit qa, input bit qb, input int cur);
    int first;
    int second;
    bit q [3];
    q[0] = 1'b0; q[1] = qa; q[2] = qb;
    if (md == 2'b00) return (ms == 2'b01) ? 1 : ((ms == 2'b10) ? 2 : 0);
    first  = sw ? 2 : 1;
    second = 3 - first;
    if (md == 2'b01 && cur != 0 && q[cur]) return cur;
    if (q[first]) return first;
    if (q[second]) return second;
    return 0;
  endfunction

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    int np;
    @(posedge clk);
    #1;
    np = want(mode, man_sel, prio_swap, m_q[0], m_q[1], m_pick);
    m_chg = (np != m_pick);
    m_pick = np;
    for (int i = 0; i < 2; i++) begin
      if (ref_los[i] | ref_fos[i]) begin
        m_run[i] = 0; m_q[i] = 1'b0;
      end else begin
        if (m_run[i] < 1000000) m_run[i]++;
        if (m_run[i] >= win(val_time)) m_q[i] = 1'b1;
      end
    end
    chk(int'(active) == m_pick, {tag, " active"}, active, m_pick);
    chk(holdover == (m_pick == 0), "R9 holdover flag", holdover, m_pick == 0);
    chk(sel_changed == m_chg, "R11 change pulse", sel_changed, m_chg);
    chk(int'(sel_report) == ((mode == 2'b00) ? 0 : m_pick), "R10 report",
        sel_report, (mode == 2'b00) ? 0 : m_pick);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(active == 2'b00 && holdover && !sel_changed && sel_report == 2'b00,
        "R1 reset state", {active, holdover, sel_changed}, 3'b001 << 1);
    rst_n = 1'b1;
    m_run[0] = 0; m_run[1] = 0; m_q[0] = 0; m_q[1] = 0; m_pick = 0; m_chg = 0;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lf;
    do_reset();
    tick("R1 first cycle");

    // R2 / R5 / R6: every window under both priorities
    for (int vt = 0; vt < 4; vt++) begin
      for (int sw = 0; sw < 2; sw++) begin
        int L;
        val_time = 2'(vt); prio_swap = sw[0]; mode = 2'b10;
        ref_los = 2'b00; ref_fos = 2'b00;
        do_reset();
        L = win(val_time);
        for (int t = 1; t <= L + 1; t++) begin
          tick("R2 window");
          if (t == L) chk(active == 2'b00, "R2 not yet valid", active, 0);
        end
        chk(int'(active) == (sw ? 2 : 1), sw ? "R6 swapped order" : "R5 default order",
            active, sw ? 2 : 1);
        // R2 restart: glitch one cycle before completion on both inputs
        ref_fos = 2'b11; tick("R2 glitch");
        ref_fos = 2'b00;
        for (int t = 1; t < L; t++) tick("R2 restart");
        ref_los = 2'b11; tick("R2 glitch2");
        ref_los = 2'b00;
        for (int t = 1; t <= L; t++) tick("R2 restart2");
        chk(active == 2'b00, "R2 restart pending", active, 0);
        tick("R2 restart done");
        chk(int'(active) == (sw ? 2 : 1), "R2 after restart", active, sw ? 2 : 1);
      end
    end

    // R3 / R7 / R8 / R9 directed, L = 2
    val_time = 2'b00; prio_swap = 1'b0; mode = 2'b10;
    do_reset();
    repeat (4) tick("R5 settle");
    ref_los = 2'b01; tick("R3 alarm A"); tick("R3 move");
    chk(active == 2'b10, "R3 fail over to B", active, 2);
    ref_los = 2'b00; repeat (3) tick("R7 return");
    chk(active == 2'b01, "R7 revert to A", active, 1);
    mode = 2'b01;
    ref_fos = 2'b01; repeat (2) tick("R8 alarm A");
    ref_fos = 2'b00; repeat (10) tick("R8 hold B");
    chk(active == 2'b10, "R8 non-revertive keeps B", active, 2);
    ref_los = 2'b11; repeat (3) tick("R9 enter");
    chk(active == 2'b00 && holdover, "R9 holdover", active, 0);
    ref_los = 2'b01; repeat (2) tick("R9 validating");
    chk(active == 2'b00, "R9 still holding", active, 0);
    tick("R9 leave");
    chk(active == 2'b10, "R9 leave to B", active, 2);

    // R4 / R10 manual sweep over all codes and alarm patterns
    mode = 2'b00;
    for (int ms = 0; ms < 4; ms++) begin
      for (int al = 0; al < 16; al++) begin
        man_sel = 2'(ms); ref_los = al[1:0]; ref_fos = al[3:2];
        tick("R4 manual");
        tick("R4 manual hold");
        chk(int'(active) == ((ms == 1) ? 1 : (ms == 2) ? 2 : 0), "R4 manual choice",
            active, (ms == 1) ? 1 : (ms == 2) ? 2 : 0);
        chk(sel_report == 2'b00, "R10 manual report", sel_report, 0);
      end
    end

    // mixed pseudo-random phase against the model
    ref_los = 2'b00; ref_fos = 2'b00;
    lf = 16'hACE1;
    for (int n = 0; n < 6000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) begin
        ref_los = lf[8:7] & lf[10:9];
        ref_fos = lf[12:11] & lf[14:13];
      end
      if (lf[7:0] == 8'h3C) mode = lf[9:8];
      if (lf[7:0] == 8'h5A) prio_swap = lf[11];
      if (lf[7:0] == 8'h77) man_sel = lf[13:12];
      if (lf[7:0] == 8'h91) val_time = {1'b0, lf[14]};
      tick("R7 R8 mixed");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule